// File: doc/BRIEF.md
# Write-Back Cache Controller with Victim Buffer

This block controls a direct-mapped data cache that holds stores locally and only writes a modified line back to memory when a miss evicts it. Requests from the processor arrive on a request/ready handshake. The address is split into tag, line index, word offset and byte offset. The tag, valid bit, dirty bit and line data are kept in internal registers. Memory is reached through a single block-wide channel. On that channel one transaction, a line read or a line write, is in flight at a time.

When a miss evicts a modified line, the controller does not write that line back first. It parks the line in a one-entry victim buffer and fetches the missing line straight away. It answers the processor as soon as the refill has been merged. Only after that does the buffered line drain to memory, and hits keep being served while it drains. Two hazards make a request wait for the drain to finish. One is a miss to the line sitting in the buffer. The other is a miss that needs the buffer while it is still occupied.

Top module: `wbcache_ctrl`

## Requirements
- R1: After reset no line is valid, the victim buffer is empty, `mem_req` and `cpu_ready` are low, and the first access to any address is handled as a miss.
- R2: An address is byte-addressed and word-aligned. Bits [1:0] are the byte offset and must be zero. Bits [3:2] select the word, bits [7:4] select the line and bits [15:8] are the tag. A request seen in idle is compared on the next edge. A read hit raises `cpu_ready` for exactly one cycle, two clock edges after the request is seen, with the word on `cpu_rdata` and no memory transaction.
- R3: A write hit replaces the addressed word and marks the line modified, without any memory write at that time.
- R4: A modified line that is evicted is written to memory later at its own block address, `{tag, index}` (address bits [15:4]), with every word the processor stored into it.
- R5: On a miss with a modified victim, the line read of the new block is started before the write of the victim.
- R6: On a miss, `cpu_ready` is raised once the refill completes, before the victim write has completed.
- R7: While the victim buffer is draining, a hit is answered with the hit latency of R2.
- R8: A memory transaction holds `mem_req`, `mem_we` and `mem_addr` stable until a cycle with `mem_ready` high, and it completes at that edge. A miss that arrives while the drain occupies the channel starts its read only after that write completes.
- R9: A miss whose victim is unmodified or invalid reads the new block without any memory write.
- R10: A write miss fetches the block, merges the stored word into it and leaves the line modified. The other words of the line keep their memory values.
- R11: A miss to the block held in the victim buffer waits until the drain is finished and returns the data last stored by the processor.
- R12: A miss with a modified victim while the buffer is still full waits for the drain, and then proceeds without losing either modified line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W-4 | Block address `{tag, index}` |
| mem_wdata | output | WORDS*DATA_W | Line written to memory |
| mem_rdata | input | WORDS*DATA_W | Line returned by memory |
| mem_ready | input | 1 | Completes the current transaction |

## Verification
The bench forces a modified eviction under a slow memory, so the refill finishes while the victim write is still pending. A controller that wrote back first would show the wrong order on the channel. One that held the processor until the drain ended would show a ready pulse after the victim had landed. Hits are issued during that drain, and a design that serialized them would miss the two-cycle hit latency. It reads back a line that was just parked in the buffer, and a design without the stall would return stale memory contents. It then evicts a second modified line while the buffer is still full, and a design that overwrote the buffer would lose stored words in the final read sweep.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CMP     = 2'd1,
        ST_WAITBUF = 2'd2,
        ST_FILL    = 2'd3
    } ctl_state_e;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RD   = 2'd1,
        CH_WR   = 2'd2
    } chan_e;

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 8,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             fill_en,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_dirty
);

    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0]            dirty;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } tag_st_t;

    tag_st_t ts_d, ts_q;

    always_comb begin
        ts_d = ts_q;
        if (fill_en) begin
            ts_d.valid[wr_idx] = 1'b1;
            ts_d.dirty[wr_idx] = fill_dirty;
            ts_d.tag[wr_idx]   = fill_tag;
        end else if (mark_en) begin
            ts_d.dirty[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign rd_tag   = ts_q.tag[rd_idx];
    assign rd_valid = ts_q.valid[rd_idx];
    assign rd_dirty = ts_q.dirty[rd_idx];

    // a store hit may only mark a line that is present (R3)
    p_mark_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mark_en |-> ts_q.valid[wr_idx]);

    // after reset nothing may look present (R1)
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ts_q.valid == '0));

endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
    parameter int LINES  = 16,
    parameter int LINE_W = 128,
    parameter int IDX_W  = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);

    logic [LINES-1:0][LINE_W-1:0] arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        if (wr_en) arr_d[wr_idx] = wr_line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arr_q <= '0;
        else        arr_q <= arr_d;
    end

    assign rd_line = arr_q[rd_idx];

endmodule

// File: rtl/wbc_victim_port.sv
module wbc_victim_port
    import wbc_pkg::*;
#(
    parameter int BLK_W  = 12,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BLK_W-1:0]  load_addr,
    input  logic [LINE_W-1:0] load_line,
    input  logic              rd_want,
    input  logic [BLK_W-1:0]  rd_addr,
    output logic              rd_done,
    output logic              buf_full,
    output logic [BLK_W-1:0]  buf_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BLK_W-1:0]  mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ready
);

    typedef struct packed {
        chan_e             chan;
        logic              full;
        logic [BLK_W-1:0]  baddr;
        logic [LINE_W-1:0] bline;
        logic [BLK_W-1:0]  raddr;
    } port_st_t;

    port_st_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (load) begin
            ps_d.full  = 1'b1;
            ps_d.baddr = load_addr;
            ps_d.bline = load_line;
        end
        case (ps_q.chan)
            CH_IDLE: begin
                // the refill read wins over the pending drain
                if (rd_want) begin
                    ps_d.chan  = CH_RD;
                    ps_d.raddr = rd_addr;
                end else if (ps_q.full) begin
                    ps_d.chan = CH_WR;
                end
            end
            CH_RD: begin
                if (mem_ready) ps_d.chan = CH_IDLE;
            end
            CH_WR: begin
                if (mem_ready) begin
                    ps_d.chan = CH_IDLE;
                    ps_d.full = 1'b0;
                end
            end
            default: ps_d.chan = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign mem_req   = (ps_q.chan != CH_IDLE);
    assign mem_we    = (ps_q.chan == CH_WR);
    assign mem_addr  = (ps_q.chan == CH_WR) ? ps_q.baddr : ps_q.raddr;
    assign mem_wdata = ps_q.bline;
    assign rd_done   = (ps_q.chan == CH_RD) && mem_ready;
    assign buf_full  = ps_q.full;
    assign buf_addr  = ps_q.baddr;

    // a transaction stays put until memory answers (R8)
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // a wanted refill on a free channel goes out as a read, never the drain (R5)
    p_read_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && rd_want) |=> (mem_req && !mem_we));

    // the buffer is never overwritten while it still holds a victim (R12)
    p_load_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !ps_q.full);

    // the buffer empties only through a completed memory write (R4)
    p_drain_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ps_q.full) |-> $past(mem_ready && mem_we));

endmodule

// File: rtl/wbcache_ctrl.sv
module wbcache_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          cpu_req,
    input  logic                                          cpu_we,
    input  logic [ADDR_W-1:0]                             cpu_addr,
    input  logic [DATA_W-1:0]                             cpu_wdata,
    output logic                                          cpu_ready,
    output logic [DATA_W-1:0]                             cpu_rdata,
    output logic                                          mem_req,
    output logic                                          mem_we,
    output logic [ADDR_W-$clog2(WORDS)-$clog2(DATA_W/8)-1:0] mem_addr,
    output logic [WORDS*DATA_W-1:0]                       mem_wdata,
    input  logic [WORDS*DATA_W-1:0]                       mem_rdata,
    input  logic                                          mem_ready
);

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFS_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int BLK_W  = ADDR_W - OFS_W - BYTE_W;
    localparam int TAG_W  = BLK_W - IDX_W;
    localparam int LINE_W = WORDS * DATA_W;

    typedef struct packed {
        ctl_state_e        st;
        logic              rdy;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [OFS_W-1:0]  req_ofs;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [BLK_W-1:0]  req_blk;

    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid;
    logic              rd_dirty;
    logic [LINE_W-1:0] rd_line;

    logic              t_fill, t_mark, t_fill_dirty;
    logic              d_wr;
    logic [LINE_W-1:0] d_line;
    logic              v_load;
    logic              rd_want, rd_done;
    logic              buf_full;
    logic [BLK_W-1:0]  buf_addr;

    logic              hit, victim_dirty;

    assign req_ofs = cpu_addr[BYTE_W +: OFS_W];
    assign req_idx = cpu_addr[BYTE_W + OFS_W +: IDX_W];
    assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_blk = cpu_addr[ADDR_W-1 -: BLK_W];

    assign hit          = rd_valid && (rd_tag == req_tag);
    assign victim_dirty = rd_valid && rd_dirty;
    assign rd_want      = (ctl_q.st == ST_FILL);

    always_comb begin
        logic [LINE_W-1:0] merged;
        ctl_d        = ctl_q;
        ctl_d.rdy    = 1'b0;
        t_fill       = 1'b0;
        t_mark       = 1'b0;
        t_fill_dirty = 1'b0;
        d_wr         = 1'b0;
        v_load       = 1'b0;
        merged       = rd_line;
        d_line       = rd_line;
        case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req && !ctl_q.rdy) ctl_d.st = ST_CMP;
            end
            ST_CMP: begin
                if (hit) begin
                    ctl_d.rdy = 1'b1;
                    ctl_d.st  = ST_IDLE;
                    if (cpu_we) begin
                        merged[req_ofs*DATA_W +: DATA_W] = cpu_wdata;
                        d_line = merged;
                        d_wr   = 1'b1;
                        t_mark = 1'b1;
                    end else begin
                        ctl_d.rdata = rd_line[req_ofs*DATA_W +: DATA_W];
                    end
                end else if (buf_full && (victim_dirty || buf_addr == req_blk)) begin
                    // buffer busy with a victim we either need or must not overwrite
                    ctl_d.st = ST_WAITBUF;
                end else begin
                    v_load   = victim_dirty;
                    ctl_d.st = ST_FILL;
                end
            end
            ST_WAITBUF: begin
                if (!buf_full) ctl_d.st = ST_CMP;
            end
            ST_FILL: begin
                if (rd_done) begin
                    merged = mem_rdata;
                    if (cpu_we) merged[req_ofs*DATA_W +: DATA_W] = cpu_wdata;
                    else        ctl_d.rdata = mem_rdata[req_ofs*DATA_W +: DATA_W];
                    d_line       = merged;
                    d_wr         = 1'b1;
                    t_fill       = 1'b1;
                    t_fill_dirty = cpu_we;
                    ctl_d.rdy    = 1'b1;
                    ctl_d.st     = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, rdy: 1'b0, rdata: '0};
        else        ctl_q <= ctl_d;
    end

    assign cpu_ready = ctl_q.rdy;
    assign cpu_rdata = ctl_q.rdata;

    wbc_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .IDX_W (IDX_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (req_idx),
        .rd_tag     (rd_tag),
        .rd_valid   (rd_valid),
        .rd_dirty   (rd_dirty),
        .fill_en    (t_fill),
        .mark_en    (t_mark),
        .wr_idx     (req_idx),
        .fill_tag   (req_tag),
        .fill_dirty (t_fill_dirty)
    );

    wbc_data_store #(
        .LINES  (LINES),
        .LINE_W (LINE_W),
        .IDX_W  (IDX_W)
    ) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_idx),
        .rd_line (rd_line),
        .wr_en   (d_wr),
        .wr_idx  (req_idx),
        .wr_line (d_line)
    );

    wbc_victim_port #(
        .BLK_W  (BLK_W),
        .LINE_W (LINE_W)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (v_load),
        .load_addr ({rd_tag, req_idx}),
        .load_line (rd_line),
        .rd_want   (rd_want),
        .rd_addr   (req_blk),
        .rd_done   (rd_done),
        .buf_full  (buf_full),
        .buf_addr  (buf_addr),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready)
    );

    // ready is a single-cycle pulse (R2)
    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // only word-aligned requests are issued (R2)
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_addr[BYTE_W-1:0] == '0));

    // a refill never completes for a block still parked in the buffer (R11)
    p_no_stale_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !(buf_full && buf_addr == req_blk));

    // a refill completion always releases the processor on the next cycle (R6)
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> cpu_ready);

endmodule

// File: tb/wbcache_ctrl_test.sv
module wbcache_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0;
    logic         cpu_we = 1'b0;
    logic [15:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic         cpu_ready;
    logic [31:0]  cpu_rdata;
    logic         mem_req;
    logic         mem_we;
    logic [11:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ready = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [127:0] bmem [int];
    logic [31:0]  shadow [int];
    int           log_we[$];
    int           log_addr[$];
    int           mem_lat = 1;
    int           wr_total = 0;

    bit ref_valid [16];
    int ref_tag [16];

    int  last_lat;
    bit  snap_req, snap_we;
    int  snap_addr, snap_wr;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbcache_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] init_word(input int blk, input int w);
        return 32'(32'hA500_0000 | (blk << 4) | w);
    endfunction

    function automatic logic [127:0] get_blk(input int blk);
        logic [127:0] r;
        if (bmem.exists(blk)) return bmem[blk];
        for (int w = 0; w < 4; w++) r[w*32 +: 32] = init_word(blk, w);
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        if (shadow.exists(a >> 2)) return shadow[a >> 2];
        return init_word(a >> 4, (a >> 2) & 3);
    endfunction

    // variable-latency memory, also watching that requests hold still (R8)
    initial begin
        bit          busy = 0;
        int          cnt = 0;
        bit          cur_we = 0;
        logic [11:0] cur_addr = '0;
        forever begin
            @(negedge clk);
            mem_ready = 1'b0;
            if (!rst_n) begin
                busy = 0;
            end else begin
                if (!busy && mem_req) begin
                    busy = 1;
                    cur_we = mem_we;
                    cur_addr = mem_addr;
                    cnt = mem_lat;
                    log_we.push_back(int'(mem_we));
                    log_addr.push_back(int'(mem_addr));
                end else if (busy) begin
                    chk(mem_req && (mem_we == cur_we) && (mem_addr == cur_addr),
                        "R8 request held stable", {mem_we, mem_addr}, {cur_we, cur_addr});
                end
                if (busy) begin
                    if (cnt == 0) begin
                        mem_ready = 1'b1;
                        busy = 0;
                        if (cur_we) begin
                            bmem[int'(cur_addr)] = mem_wdata;
                            wr_total++;
                        end else begin
                            mem_rdata = get_blk(int'(cur_addr));
                        end
                    end else begin
                        cnt--;
                    end
                end
            end
        end
    end

    task automatic access(input bit we, input logic [15:0] a, input logic [31:0] wd, input string rq);
        int idx = (int'(a) >> 4) & 15;
        int tg  = int'(a) >> 8;
        bit hit = ref_valid[idx] && (ref_tag[idx] == tg);
        int lat = 0;
        logic [31:0] ex;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready && lat < 400);
        last_lat = lat;
        snap_req = mem_req; snap_we = mem_we; snap_addr = int'(mem_addr); snap_wr = wr_total;
        chk(cpu_ready, {rq, " ready reached"}, lat, 0);
        if (hit) chk(lat == 2, {rq, " hit latency"}, lat, 2);
        else     chk(lat > 2, {rq, " miss latency"}, lat, 3);
        if (!we) begin
            ex = exp_read(int'(a));
            chk(cpu_rdata == ex, {rq, " read data"}, cpu_rdata, ex);
        end else begin
            shadow[int'(a) >> 2] = wd;
        end
        ref_valid[idx] = 1;
        ref_tag[idx] = tg;
        cpu_req = 1'b0; cpu_we = 1'b0;
        @(negedge clk);
        chk(!cpu_ready, "R2 ready is one cycle", cpu_ready, 0);
    endtask

    task automatic wait_drain();
        int quiet = 0;
        for (int i = 0; i < 500 && quiet < 4; i++) begin
            @(negedge clk);
            if (mem_req) quiet = 0; else quiet++;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all-R actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int n0, l0;
        for (int i = 0; i < 16; i++) begin ref_valid[i] = 0; ref_tag[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and cold miss
        chk(!cpu_ready, "R1 ready low after reset", cpu_ready, 0);
        chk(!mem_req, "R1 no memory request after reset", mem_req, 0);
        access(0, 16'h0100, 0, "R1");

        // R2: read hits, no memory traffic
        l0 = log_we.size();
        access(0, 16'h0100, 0, "R2");
        access(0, 16'h0108, 0, "R2");
        chk(log_we.size() == l0, "R2 hit without memory traffic", log_we.size(), l0);

        // R3: write hit stays in the cache
        n0 = wr_total;
        access(1, 16'h0104, 32'h1111_0001, "R3");
        access(0, 16'h0104, 0, "R3");
        chk(wr_total == n0, "R3 no write on store hit", wr_total, n0);

        // R10: write miss allocates and merges
        access(1, 16'h0218, 32'h2222_0002, "R10");
        access(0, 16'h0218, 0, "R10");
        access(0, 16'h021C, 0, "R10");

        // R9: clean victim, no write-back
        access(0, 16'h0020, 0, "R9");
        n0 = wr_total;
        access(0, 16'h0120, 0, "R9");
        wait_drain();
        chk(wr_total == n0, "R9 clean eviction writes nothing", wr_total, n0);

        // R5 R6 R7 R8 R4: modified eviction with slow memory
        mem_lat = 6;
        n0 = wr_total;
        access(0, 16'h0300, 0, "R6");
        chk(snap_wr == n0, "R6 ready before victim write completes", snap_wr, n0);
        access(0, 16'h0120, 0, "R7");
        chk(snap_req && snap_we && snap_addr == 'h010, "R7 hit served during drain",
            {snap_req, snap_we, 12'(snap_addr)}, {2'b11, 12'h010});
        l0 = log_we.size();
        chk(l0 >= 2 && log_we[l0-2] == 0 && log_addr[l0-2] == 'h030,
            "R5 refill read issued first", log_addr[l0-2], 'h030);
        chk(l0 >= 2 && log_we[l0-1] == 1 && log_addr[l0-1] == 'h010,
            "R5 victim write issued second", log_addr[l0-1], 'h010);
        access(0, 16'h0428, 0, "R8");
        l0 = log_we.size();
        chk(log_we[l0-2] == 1 && log_addr[l0-2] == 'h010 && log_we[l0-1] == 0 && log_addr[l0-1] == 'h042,
            "R8 miss read after drain write", log_addr[l0-1], 'h042);
        wait_drain();
        chk(bmem.exists('h010) && bmem['h010][63:32] == 32'h1111_0001,
            "R4 victim word written back", bmem.exists('h010) ? bmem['h010][63:32] : 0, 32'h1111_0001);
        chk(bmem.exists('h010) && bmem['h010][31:0] == init_word('h010, 0),
            "R4 untouched word written back", bmem.exists('h010) ? bmem['h010][31:0] : 0, init_word('h010, 0));

        // R11: miss to the block parked in the buffer
        mem_lat = 5;
        access(1, 16'h0034, 32'h3333_0003, "R11");
        access(0, 16'h0134, 0, "R11");
        access(0, 16'h0034, 0, "R11");
        l0 = log_we.size();
        chk(log_we[l0-2] == 1 && log_addr[l0-2] == 'h003 && log_we[l0-1] == 0 && log_addr[l0-1] == 'h003,
            "R11 drain before re-read", log_addr[l0-2], 'h003);

        // R12: modified eviction while buffer is full
        mem_lat = 4;
        access(1, 16'h0040, 32'h4444_0001, "R12");
        access(1, 16'h0140, 32'h4444_0002, "R12");
        access(1, 16'h0240, 32'h4444_0003, "R12");
        access(0, 16'h0240, 0, "R12");
        access(0, 16'h0040, 0, "R12");
        access(0, 16'h0140, 0, "R12");
        wait_drain();
        chk(bmem.exists('h024) && bmem['h024][31:0] == 32'h4444_0003,
            "R4 second victim written back", bmem.exists('h024) ? bmem['h024][31:0] : 0, 32'h4444_0003);

        // R2: zero-latency memory, miss then hit
        mem_lat = 0;
        access(0, 16'h0550, 0, "R2");
        access(0, 16'h0550, 0, "R2");

        // R3 R4: every stored word reads back
        mem_lat = 2;
        foreach (shadow[k]) access(0, 16'(k << 2), 0, "R3");
        wait_drain();

        done = 1;
        summary();
        $finish;
    end

endmodule